// File: doc/BRIEF.md
# Programming Command Frame Receiver

This block follows a byte-wide serial receiver on a single-wire flash-programming link. It gathers the incoming bytes into command frames. A frame opens with 0x01 and carries a length byte, a command code, zero or more data bytes and a checksum, and it closes with 0x03. The block checks the structure and the checksum of every frame. When a frame is good, it raises a one-cycle command strobe together with the command code, the length, the data bytes and a decoded command kind. When a frame is bad, it raises a one-cycle error strobe with a cause code instead.

For the blank-check command, the block also splits the payload into a 24-bit first address, a 24-bit last address and a mode byte. It flags whether that mode asks for the whole area ahead of a chip erase. An idle-gap watchdog drops a frame that stalls partway through, and the block then goes back to looking for a start byte.

Top module: `prog_cmd_rx`

## Requirements
- R1: While no frame is open, any byte other than 0x01 is dropped with no command strobe and no error strobe. Only 0x01 opens a frame.
- R2: The bytes of a frame arrive in this order: 0x01, length L, command code, L-1 data bytes, checksum, 0x03. A good frame raises `cmd_valid` for one cycle, in the cycle after the 0x03 byte is accepted. In that cycle `cmd_code` and `cmd_len` show the frame's values. Data byte i sits at `cmd_data[8i+7:8i]`, and any byte position the frame did not fill reads zero.
- R3: The 8-bit sum of the length, the command code, every data byte and the checksum byte must be zero. If it is not, the frame gives `err_code` 3 (checksum) in the cycle after the closing byte.
- R4: If the closing byte is not 0x03, the frame gives `err_code` 2 (framing). This cause wins over a checksum mismatch.
- R5: A length byte of 0, or a length above MAX_DATA+1, gives `err_code` 1 (length) in the cycle after the length byte. The frame is dropped and the block waits for the next 0x01.
- R6: A good frame with command code 0x32 and length 8 raises `bc_valid` together with `cmd_valid`. Data bytes 0..2 form `bc_start` and bytes 3..5 form `bc_end`, each ordered high, middle, low (bits 23:16, 15:8, 7:0). Byte 6 drives `bc_mode`, and `bc_whole` is 1 only when that mode byte is 0x01.
- R7: A frame with command code 0x32 whose length is not 8 gives `err_code` 1 at its closing byte, provided its framing and checksum are correct.
- R8: `cmd_kind` encodes the command code: 0xC5 gives 1 (version), 0x14 gives 2 (verify), 0x20 gives 3 (erase), 0x32 gives 4 (blank check), and any other code gives 0.
- R9: While a frame is open, GAP_CYCLES cycles in a row with no input byte give `err_code` 4 (timeout) on the last of those cycles, and the frame is dropped. A byte that arrives on that same cycle keeps the frame alive.
- R10: `cmd_valid` and `err_valid` are never high together. `err_code` reads 0 whenever `err_valid` is low.
- R11: While reset is held, every strobe and `err_code` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle strobe for a good frame |
| cmd_code | output | 8 | Command code of the frame |
| cmd_len | output | 8 | Length byte of the frame |
| cmd_kind | output | 3 | Decoded command kind |
| cmd_data | output | 8*MAX_DATA | Data bytes, byte i at bits 8i+7:8i |
| bc_valid | output | 1 | Good blank-check frame strobe |
| bc_start | output | 24 | Blank-check first address |
| bc_end | output | 24 | Blank-check last address |
| bc_mode | output | 8 | Blank-check mode byte |
| bc_whole | output | 1 | Mode byte asks for the whole area |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 3 | 1 length, 2 framing, 3 checksum, 4 timeout |

## Verification
The watchdog expiry and a byte arrival can fall in the same cycle, and the bench provokes this from both sides. In one frame the next byte arrives after exactly GAP_CYCLES-1 idle cycles, so it lands on the cycle that would otherwise expire. In another frame the bytes stop for a full GAP_CYCLES. The first case must finish as a good frame and the second must give a timeout strobe on the expiring cycle. The bench judges both against a behavioural model that counts idle cycles on its own. A second collision, a bad closing byte combined with a bad checksum, must report framing alone.

// File: rtl/prog_cmd_pkg.sv
// Package: shared constants and encodings for the programming command receiver.
// Assumes: byte-wide input; all codes below are fixed by the link protocol.
package prog_cmd_pkg;
    localparam logic [7:0] SOH_BYTE  = 8'h01;
    localparam logic [7:0] ETX_BYTE  = 8'h03;
    localparam logic [7:0] OP_VER    = 8'hC5;
    localparam logic [7:0] OP_VERIFY = 8'h14;
    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_BCHK   = 8'h32;
    localparam logic [7:0] BCHK_LEN  = 8'h08;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_LEN   = 3'd1,
        ERR_FRAME = 3'd2,
        ERR_SUM   = 3'd3,
        ERR_GAP   = 3'd4
    } err_t;

    typedef enum logic [2:0] {
        KIND_OTHER  = 3'd0,
        KIND_VER    = 3'd1,
        KIND_VERIFY = 3'd2,
        KIND_ERASE  = 3'd3,
        KIND_BCHK   = 3'd4
    } kind_t;

    typedef enum logic [2:0] {
        ST_HUNT, ST_LEN, ST_CMD, ST_DATA, ST_SUM, ST_END
    } rx_state_t;
endpackage

// File: rtl/prog_cmd_gap.sv
// Module: idle-gap watchdog. Counts idle cycles while a frame is open and
// raises expire on the GAP_CYCLES-th idle cycle in a row.
// Assumes: armed drops in the cycle after expire (the frame FSM returns to hunt).
module prog_cmd_gap #(
    parameter int GAP_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic rx_valid,
    output logic expire
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] LAST = GW'(GAP_CYCLES - 1);

    logic [GW-1:0] idle_cnt;

    // Idle-cycle counter: cleared by any byte or when no frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || rx_valid || expire) idle_cnt <= '0;
        else                                         idle_cnt <= idle_cnt + 1'b1;
    end

    // Expiry: a byte arriving on the last idle cycle wins over the timeout.
    always_comb expire = armed && !rx_valid && (idle_cnt == LAST);

    p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST);
endmodule

// File: rtl/prog_cmd_buf.sv
// Module: payload byte store. One register per data byte position; cleared
// when a frame opens so positions a short frame leaves unwritten read zero.
// Assumes: wr_idx < MAX_DATA whenever wr_en is high.
module prog_cmd_buf #(
    parameter int MAX_DATA = 15,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_byte,
    output logic [8*MAX_DATA-1:0] data_flat
);
    for (genvar i = 0; i < MAX_DATA; i++) begin : g_slot
        logic [7:0] slot_q;
        // Slot i: cleared at frame open, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                          slot_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))      slot_q <= wr_byte;
        end
        assign data_flat[8*i +: 8] = slot_q;
    end
endmodule

// File: rtl/prog_cmd_fsm.sv
// Module: frame sequencer. Walks start, length, code, data, checksum, end
// bytes, keeps a running 8-bit sum and issues either a command or an error strobe.
// Assumes: at most one byte per cycle; expire is only high when rx_valid is low.
module prog_cmd_fsm
    import prog_cmd_pkg::*;
#(
    parameter int MAX_DATA = 15,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             expire,
    output logic             armed,
    output logic             clr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             cmd_valid,
    output logic [7:0]       cmd_code,
    output logic [7:0]       cmd_len,
    output logic             err_valid,
    output logic [2:0]       err_code
);
    localparam logic [7:0] LEN_MAX = 8'(MAX_DATA + 1);

    rx_state_t        state;
    logic [7:0]       len_q, code_q, sum_q;
    logic [IDX_W-1:0] idx_q;
    err_t             err_q;

    // Sequencer: byte-by-byte frame walk, checks at the length and end bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT; len_q <= '0; code_q <= '0; sum_q <= '0;
            idx_q <= '0; cmd_valid <= 1'b0; err_valid <= 1'b0; err_q <= ERR_NONE;
        end else begin
            cmd_valid <= 1'b0;
            err_valid <= 1'b0;
            err_q     <= ERR_NONE;
            if (expire) begin
                err_valid <= 1'b1; err_q <= ERR_GAP; state <= ST_HUNT;
            end else if (rx_valid) begin
                case (state)
                    ST_HUNT: if (rx_byte == SOH_BYTE) state <= ST_LEN;
                    ST_LEN: begin
                        if (rx_byte == 8'h00 || rx_byte > LEN_MAX) begin
                            err_valid <= 1'b1; err_q <= ERR_LEN; state <= ST_HUNT;
                        end else begin
                            len_q <= rx_byte; sum_q <= rx_byte; state <= ST_CMD;
                        end
                    end
                    ST_CMD: begin
                        code_q <= rx_byte;
                        sum_q  <= sum_q + rx_byte;
                        idx_q  <= '0;
                        state  <= (len_q == 8'd1) ? ST_SUM : ST_DATA;
                    end
                    ST_DATA: begin
                        sum_q <= sum_q + rx_byte;
                        idx_q <= idx_q + 1'b1;
                        if (8'(idx_q) + 8'd2 == len_q) state <= ST_SUM;
                    end
                    ST_SUM: begin
                        sum_q <= sum_q + rx_byte;
                        state <= ST_END;
                    end
                    ST_END: begin
                        state <= ST_HUNT;
                        if (rx_byte != ETX_BYTE) begin
                            err_valid <= 1'b1; err_q <= ERR_FRAME;
                        end else if (sum_q != 8'h00) begin
                            err_valid <= 1'b1; err_q <= ERR_SUM;
                        end else if (code_q == OP_BCHK && len_q != BCHK_LEN) begin
                            err_valid <= 1'b1; err_q <= ERR_LEN;
                        end else begin
                            cmd_valid <= 1'b1;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // Side signals for the watchdog and the payload store.
    always_comb begin
        armed  = (state != ST_HUNT);
        clr    = rx_valid && (state == ST_HUNT) && (rx_byte == SOH_BYTE);
        wr_en  = rx_valid && (state == ST_DATA);
        wr_idx = idx_q;
    end

    assign cmd_code = code_q;
    assign cmd_len  = len_q;
    assign err_code = err_q;

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && err_valid));
    p_errzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> err_code == 3'd0);
    p_endbyte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(rx_valid && rx_byte == ETX_BYTE));
    p_lenrange_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != 8'h00 && cmd_len <= LEN_MAX));
    p_gapidle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 3'd4) |-> $past(!rx_valid));
endmodule

// File: rtl/prog_cmd_decode.sv
// Module: command decoder. Maps the code to a kind and splits the
// blank-check payload into addresses and mode.
// Assumes: MAX_DATA >= 7 so the blank-check payload fits the store.
module prog_cmd_decode
    import prog_cmd_pkg::*;
#(
    parameter int MAX_DATA = 15
) (
    input  logic                  cmd_valid,
    input  logic [7:0]            cmd_code,
    input  logic [8*MAX_DATA-1:0] cmd_data,
    output logic [2:0]            cmd_kind,
    output logic                  bc_valid,
    output logic [23:0]           bc_start,
    output logic [23:0]           bc_end,
    output logic [7:0]            bc_mode,
    output logic                  bc_whole
);
    kind_t kind;

    // Code to kind map.
    always_comb begin
        case (cmd_code)
            OP_VER:    kind = KIND_VER;
            OP_VERIFY: kind = KIND_VERIFY;
            OP_ERASE:  kind = KIND_ERASE;
            OP_BCHK:   kind = KIND_BCHK;
            default:   kind = KIND_OTHER;
        endcase
    end

    // Blank-check fields, high byte first.
    always_comb begin
        cmd_kind = kind;
        bc_valid = cmd_valid && (kind == KIND_BCHK);
        bc_start = {cmd_data[7:0],   cmd_data[15:8],  cmd_data[23:16]};
        bc_end   = {cmd_data[31:24], cmd_data[39:32], cmd_data[47:40]};
        bc_mode  = cmd_data[55:48];
        bc_whole = (bc_mode == 8'h01);
    end
endmodule

// File: rtl/prog_cmd_rx.sv
// Module: top of the programming command frame receiver.
// Assumes: bytes come from an upstream serial receiver, one per rx_valid pulse;
// MAX_DATA between 7 and 254.
module prog_cmd_rx #(
    parameter int MAX_DATA   = 15,
    parameter int GAP_CYCLES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    output logic                  cmd_valid,
    output logic [7:0]            cmd_code,
    output logic [7:0]            cmd_len,
    output logic [2:0]            cmd_kind,
    output logic [8*MAX_DATA-1:0] cmd_data,
    output logic                  bc_valid,
    output logic [23:0]           bc_start,
    output logic [23:0]           bc_end,
    output logic [7:0]            bc_mode,
    output logic                  bc_whole,
    output logic                  err_valid,
    output logic [2:0]            err_code
);
    localparam int IDX_W = $clog2(MAX_DATA + 1);

    logic             armed, expire, clr, wr_en;
    logic [IDX_W-1:0] wr_idx;

    prog_cmd_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk(clk), .rst_n(rst_n), .armed(armed), .rx_valid(rx_valid), .expire(expire)
    );

    prog_cmd_fsm #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .expire(expire), .armed(armed), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_len(cmd_len),
        .err_valid(err_valid), .err_code(err_code)
    );

    prog_cmd_buf #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_byte(rx_byte), .data_flat(cmd_data)
    );

    prog_cmd_decode #(.MAX_DATA(MAX_DATA)) u_dec (
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
        .cmd_kind(cmd_kind), .bc_valid(bc_valid), .bc_start(bc_start),
        .bc_end(bc_end), .bc_mode(bc_mode), .bc_whole(bc_whole)
    );

    p_bclen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (cmd_valid && cmd_len == 8'h08));
endmodule

// File: tb/prog_cmd_rx_test.sv
// Bench: behavioural queue model compared with the design on every clock.
module prog_cmd_rx_test;
    localparam int MAX_DATA = 15;
    localparam int GAP      = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic cmd_valid, bc_valid, bc_whole, err_valid;
    logic [7:0] cmd_code, cmd_len, bc_mode;
    logic [2:0] cmd_kind, err_code;
    logic [8*MAX_DATA-1:0] cmd_data;
    logic [23:0] bc_start, bc_end;

    always #2.5 clk = ~clk;

    prog_cmd_rx #(.MAX_DATA(MAX_DATA), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_len(cmd_len),
        .cmd_kind(cmd_kind), .cmd_data(cmd_data), .bc_valid(bc_valid),
        .bc_start(bc_start), .bc_end(bc_end), .bc_mode(bc_mode),
        .bc_whole(bc_whole), .err_valid(err_valid), .err_code(err_code)
    );

    int n_chk = 0, n_fail = 0, n_cmd_seen = 0, n_cmd_exp = 0;
    string cur_req = "R11";
    bit started = 0;

    // Reference model state.
    bit in_frame = 0;
    int gap_cnt = 0;
    logic [7:0] q[$];
    logic [7:0] pl[$];
    logic exp_cmd = 0, exp_err = 0, exp_bc = 0, exp_whole = 0;
    logic [2:0] exp_ecode = 0, exp_kind = 0;
    logic [7:0] exp_code = 0, exp_len = 0, exp_mode = 0;
    logic [23:0] exp_start = 0, exp_end = 0;
    logic [8*MAX_DATA-1:0] exp_data = '0;

    function automatic logic [2:0] kind_of(input logic [7:0] c);
        case (c)
            8'hC5: return 3'd1;
            8'h14: return 3'd2;
            8'h20: return 3'd3;
            8'h32: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    // Model: behavioural queue-based frame judge, one step per clock.
    always @(posedge clk) begin
        started = 1;
        exp_cmd = 0; exp_err = 0; exp_ecode = 0; exp_bc = 0;
        if (!rst_n) begin
            in_frame = 0; q.delete(); gap_cnt = 0;
        end else if (in_frame && !rx_valid) begin
            gap_cnt++;
            if (gap_cnt == GAP) begin
                exp_err = 1; exp_ecode = 4; in_frame = 0;
            end
        end else if (rx_valid && !in_frame) begin
            if (rx_byte == 8'h01) begin in_frame = 1; q.delete(); gap_cnt = 0; end
        end else if (rx_valid) begin
            int len;
            logic [7:0] s;
            gap_cnt = 0;
            q.push_back(rx_byte);
            len = q[0];
            if (q.size() == 1 && (len == 0 || len > MAX_DATA + 1)) begin
                exp_err = 1; exp_ecode = 1; in_frame = 0;
            end else if (q.size() == len + 3) begin
                in_frame = 0;
                s = 0;
                for (int k = 0; k <= len + 1; k++) s = s + q[k];
                if (q[len + 2] != 8'h03) begin exp_err = 1; exp_ecode = 2; end
                else if (s != 0) begin exp_err = 1; exp_ecode = 3; end
                else if (q[1] == 8'h32 && len != 8) begin exp_err = 1; exp_ecode = 1; end
                else begin
                    exp_cmd = 1; n_cmd_exp++;
                    exp_code = q[1]; exp_len = q[0]; exp_kind = kind_of(q[1]);
                    exp_data = '0;
                    for (int k = 2; k <= len; k++) exp_data[8*(k-2) +: 8] = q[k];
                    exp_bc = (q[1] == 8'h32);
                    if (exp_bc) begin
                        exp_start = {q[2], q[3], q[4]};
                        exp_end   = {q[5], q[6], q[7]};
                        exp_mode  = q[8];
                        exp_whole = (q[8] == 8'h01);
                    end
                end
            end
        end
    end

    // Compare: design outputs against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            if (cmd_valid) n_cmd_seen++;
            check(cmd_valid === exp_cmd, "cmd_valid", 128'(cmd_valid), 128'(exp_cmd));
            check(err_valid === exp_err, "err_valid", 128'(err_valid), 128'(exp_err));
            check(err_code === exp_ecode, "err_code", 128'(err_code), 128'(exp_ecode));
            check(bc_valid === exp_bc, "bc_valid", 128'(bc_valid), 128'(exp_bc));
            if (exp_cmd) begin
                check(cmd_code === exp_code, "cmd_code", 128'(cmd_code), 128'(exp_code));
                check(cmd_len === exp_len, "cmd_len", 128'(cmd_len), 128'(exp_len));
                check(cmd_kind === exp_kind, "R8 cmd_kind", 128'(cmd_kind), 128'(exp_kind));
                check(cmd_data === exp_data, "cmd_data", 128'(cmd_data), 128'(exp_data));
            end
            if (exp_bc) begin
                check(bc_start === exp_start, "R6 bc_start", 128'(bc_start), 128'(exp_start));
                check(bc_end === exp_end, "R6 bc_end", 128'(bc_end), 128'(exp_end));
                check(bc_mode === exp_mode, "R6 bc_mode", 128'(bc_mode), 128'(exp_mode));
                check(bc_whole === exp_whole, "R6 bc_whole", 128'(bc_whole), 128'(exp_whole));
            end
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); rx_valid = 1'b0; rx_byte = 8'hEE; end
    endtask

    // Sends a frame around pl; sum_err spoils the checksum, end_b is the closing byte.
    task automatic send(input logic [7:0] code, input int gap,
                        input logic [7:0] sum_err, input logic [7:0] end_b);
        logic [7:0] len, s;
        len = 8'(pl.size() + 1);
        s = len + code;
        foreach (pl[k]) s = s + pl[k];
        put(8'h01); if (gap > 0) idle(gap);
        put(len);   if (gap > 0) idle(gap);
        put(code);  if (gap > 0) idle(gap);
        foreach (pl[k]) begin put(pl[k]); if (gap > 0) idle(gap); end
        put(8'(-s) ^ sum_err); if (gap > 0) idle(gap);
        put(end_b);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        // R11: outputs quiet during reset.
        repeat (4) @(negedge clk);
        check(cmd_valid === 0 && err_valid === 0 && err_code === 0 && bc_valid === 0,
              "R11 reset outputs", 128'({cmd_valid, err_valid, err_code}), 128'(0));
        rst_n = 1'b1;
        idle(2);

        cur_req = "R1"; // noise while hunting
        put(8'h55); put(8'h03); put(8'hFF); put(8'h00); idle(3);

        cur_req = "R2"; // version, verify, erase back to back
        pl = {}; send(8'hC5, 0, 0, 8'h03);
        pl = {}; send(8'h14, 0, 0, 8'h03);
        pl = {}; send(8'h20, 0, 0, 8'h03); idle(2);

        cur_req = "R8"; // unknown code with data
        pl = {8'hAA, 8'h55}; send(8'h77, 0, 0, 8'h03); idle(2);

        cur_req = "R6"; // blank check, single block then whole area
        pl = {8'h00, 8'h00, 8'h00, 8'h0B, 8'hFF, 8'hFF, 8'h00}; send(8'h32, 0, 0, 8'h03);
        pl = {8'h12, 8'h34, 8'h56, 8'hAB, 8'hCD, 8'hEF, 8'h01}; send(8'h32, 1, 0, 8'h03); idle(2);

        cur_req = "R3"; // bad checksum
        pl = {8'h10}; send(8'h14, 0, 8'h01, 8'h03); idle(2);

        cur_req = "R4"; // bad end byte, then bad end plus bad sum
        pl = {}; send(8'hC5, 0, 0, 8'h04);
        pl = {8'h09}; send(8'h20, 0, 8'h80, 8'h02); idle(2);

        cur_req = "R5"; // zero, over-long, then maximum length
        put(8'h01); put(8'h00); idle(2);
        put(8'h01); put(8'(MAX_DATA + 2)); put(8'hC5); idle(2);
        pl = {};
        for (int k = 0; k < MAX_DATA; k++) pl.push_back(8'(k * 17 + 3));
        send(8'h20, 0, 0, 8'h03); idle(2);
        pl = {8'h42}; send(8'hC5, 0, 0, 8'h03); idle(2); // short frame after long: upper bytes zero

        cur_req = "R7"; // blank check with wrong length
        pl = {8'h01, 8'h02}; send(8'h32, 0, 0, 8'h03); idle(2);

        cur_req = "R9"; // byte on the expiring cycle keeps frame; full gap drops it
        pl = {8'h05}; send(8'hC5, GAP - 1, 0, 8'h03); idle(2);
        put(8'h01); put(8'h08); put(8'h32); put(8'h00); idle(GAP + 2);
        pl = {}; send(8'hC5, 0, 0, 8'h03); idle(3);

        cur_req = "R10";
        check(n_cmd_seen == n_cmd_exp, "R2 command strobe count", 128'(n_cmd_seen), 128'(n_cmd_exp));
        summary();
        $finish;
    end
endmodule